// File: doc/BRIEF.md
# Receive Decode-Error Symbol Substitution

This block sits on the receive path just after a per-byte 8b/10b decoder. The decoder delivers a 16-bit word that holds two symbols side by side. Each symbol comes with its own control (K) flag and its own decode-error flag, and one valid bit covers the whole word. When a symbol fails to decode, the block replaces that symbol alone with the bad-symbol marker, 0xFE sent as a control character. In the same output cycle, the 3-bit receive status carries the decode-error code. Symbols that decoded correctly pass through untouched.

The path has one register stage. Data, K flags, valid and status therefore leave together, one clock after they enter. The link layer downstream can see exactly which position in the word was corrupted and still use the neighbouring symbol.

Top module: `rx_err_sub`

## Requirements
- R1: While reset is high, and on the first output after it, out_valid, out_data, out_k and out_status are all zero.
- R2: Every input word appears on the outputs exactly one clock later, and out_valid equals the in_valid sampled on that earlier edge.
- R3: With in_valid high and no error flag set, both symbols and both K flags pass through unchanged.
- R4: With in_valid high and in_err[i] set, symbol i on the output is 0xFE and out_k[i] is 1.
- R5: When only one symbol of a word has an error, the other symbol and its K flag pass through unchanged.
- R6: The status is 3'b100 in the same output cycle in which a 0xFE substitution appears. When both symbols are in error, both are replaced and the single status value 3'b100 is reported.
- R7: A valid word with no error flag gives status 3'b000.
- R8: While in_valid is low, the error flags are ignored: data and K pass through unchanged, status is 3'b000 and out_valid is 0.
- R9: Symbol N sits on bits [7:0] and symbol N+1 on bits [15:8]. Error flag bit 0 and K bit 0 belong to bits [7:0], and bit 1 of each belongs to bits [15:8].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 16 | Two decoded symbols; symbol N on [7:0] |
| in_k | input | 2 | Per-symbol control flag |
| in_err | input | 2 | Per-symbol decode-error flag |
| out_valid | output | 1 | Registered valid |
| out_data | output | 16 | Symbols after substitution |
| out_k | output | 2 | K flags after substitution |
| out_status | output | 3 | 000 = no error, 100 = decode error |

## Verification
The hardest case is a word in which exactly one symbol is bad while its neighbour carries a data value or a control flag that must survive. A mistake in lane indexing would otherwise look correct. The stimulus sends single-error words in each lane against distinctive neighbour bytes and neighbour K values, then both-lane errors, and then error flags raised while valid is low. It also runs words back to back, so that a stale substitution that leaked into the following cycle would show up.

// File: rtl/rx_err_sub_pkg.sv
`timescale 1ns/1ps
package rx_err_sub_pkg;
  localparam int          STAT_W       = 3;
  localparam logic [2:0]  STAT_OK      = 3'b000;
  localparam logic [2:0]  STAT_DEC_ERR = 3'b100;
  localparam logic [7:0]  SYM_BAD      = 8'hFE;
endpackage

// File: rtl/rx_err_sub_lane.sv
`timescale 1ns/1ps
module rx_err_sub_lane #(
  parameter int SYM_W = 8,
  parameter logic [SYM_W-1:0] MARK = '1
) (
  input  logic             valid,
  input  logic [SYM_W-1:0] sym_i,
  input  logic             k_i,
  input  logic             err_i,
  output logic [SYM_W-1:0] sym_o,
  output logic             k_o,
  output logic             hit_o
);
  always_comb begin
    hit_o = valid & err_i;
    if (hit_o) begin
      sym_o = MARK;
      k_o   = 1'b1;
    end else begin
      sym_o = sym_i;
      k_o   = k_i;
    end
  end
endmodule

// File: rtl/rx_err_sub_stat.sv
`timescale 1ns/1ps
module rx_err_sub_stat
  import rx_err_sub_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic [LANES-1:0]  hits,
  output logic [STAT_W-1:0] status
);
  always_comb begin
    if (|hits) status = STAT_DEC_ERR;
    else       status = STAT_OK;
  end
endmodule

// File: rtl/rx_err_sub.sv
`timescale 1ns/1ps
module rx_err_sub
  import rx_err_sub_pkg::*;
#(
  parameter int LANES = 2,
  parameter int SYM_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [LANES*SYM_W-1:0] in_data,
  input  logic [LANES-1:0]       in_k,
  input  logic [LANES-1:0]       in_err,
  output logic                   out_valid,
  output logic [LANES*SYM_W-1:0] out_data,
  output logic [LANES-1:0]       out_k,
  output logic [STAT_W-1:0]      out_status
);
  localparam int DW = LANES * SYM_W;
  localparam logic [SYM_W-1:0] MARK = SYM_W'(SYM_BAD);

  logic [DW-1:0]     sub_data;
  logic [LANES-1:0]  sub_k;
  logic [LANES-1:0]  sub_hit;
  logic [STAT_W-1:0] sub_stat;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    rx_err_sub_lane #(.SYM_W(SYM_W), .MARK(MARK)) lane_i (
      .valid (in_valid),
      .sym_i (in_data[g*SYM_W +: SYM_W]),
      .k_i   (in_k[g]),
      .err_i (in_err[g]),
      .sym_o (sub_data[g*SYM_W +: SYM_W]),
      .k_o   (sub_k[g]),
      .hit_o (sub_hit[g])
    );
  end

  rx_err_sub_stat #(.LANES(LANES)) stat_i (
    .hits   (sub_hit),
    .status (sub_stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      out_k      <= '0;
      out_status <= STAT_OK;
    end else begin
      out_valid  <= in_valid;
      out_data   <= sub_data;
      out_k      <= sub_k;
      out_status <= sub_stat;
    end
  end
endmodule

// File: rtl/rx_err_sub_chk.sv
`timescale 1ns/1ps
module rx_err_sub_chk #(
  parameter int LANES = 2,
  parameter int SYM_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   in_valid,
  input logic [LANES*SYM_W-1:0] in_data,
  input logic [LANES-1:0]       in_k,
  input logic [LANES-1:0]       in_err,
  input logic                   out_valid,
  input logic [LANES*SYM_W-1:0] out_data,
  input logic [LANES-1:0]       out_k,
  input logic [2:0]             out_status
);
  localparam logic [SYM_W-1:0] MARK = SYM_W'(8'hFE);

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid));

  assert_status_err_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && ($past(in_err) != '0)) |-> out_status == 3'b100);

  assert_status_clean_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !($past(in_valid) && ($past(in_err) != '0))) |-> out_status == 3'b000);

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_edb_sub_R4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(in_valid) && $past(in_err[i]))
        |-> (out_data[i*SYM_W +: SYM_W] == MARK) && out_k[i]);

    assert_pass_through_R5: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !($past(in_valid) && $past(in_err[i])))
        |-> (out_data[i*SYM_W +: SYM_W] == $past(in_data[i*SYM_W +: SYM_W]))
            && (out_k[i] == $past(in_k[i])));
  end
endmodule

bind rx_err_sub rx_err_sub_chk #(.LANES(LANES), .SYM_W(SYM_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
  .in_k(in_k), .in_err(in_err), .out_valid(out_valid),
  .out_data(out_data), .out_k(out_k), .out_status(out_status)
);

// File: tb/rx_err_sub_tb_top.sv
`timescale 1ns/1ps
module rx_err_sub_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic [1:0]  in_k = '0;
  logic [1:0]  in_err = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic [1:0]  out_k;
  logic [2:0]  out_status;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic        v;
    logic [15:0] d;
    logic [1:0]  k;
    logic [2:0]  s;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  rx_err_sub dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_k(in_k), .in_err(in_err), .out_valid(out_valid),
    .out_data(out_data), .out_k(out_k), .out_status(out_status)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(string tag, logic v, logic [15:0] d, logic [1:0] k, logic [1:0] e);
    exp_t x;
    @(negedge clk);
    in_valid = v; in_data = d; in_k = k; in_err = e;
    x.v = v; x.d = d; x.k = k; x.s = 3'b000; x.tag = tag;
    for (int i = 0; i < 2; i++) begin
      if (v && e[i]) begin
        x.d[i*8 +: 8] = 8'hFE;
        x.k[i] = 1'b1;
        x.s = 3'b100;
      end
    end
    q.push_back(x);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && q.size() > 0) begin
      exp_t x;
      x = q.pop_front();
      chk({x.tag, " R2 valid"}, 32'(out_valid), 32'(x.v));
      chk({x.tag, " R9 byte0"}, 32'(out_data[7:0]), 32'(x.d[7:0]));
      chk({x.tag, " R9 byte1"}, 32'(out_data[15:8]), 32'(x.d[15:8]));
      chk({x.tag, " k"}, 32'(out_k), 32'(x.k));
      chk({x.tag, " status"}, 32'(out_status), 32'(x.s));
    end
  end

  initial begin
    in_valid = 1'b1; in_data = 16'hA5C3; in_k = 2'b11; in_err = 2'b11;
    repeat (3) @(negedge clk);
    chk("R1 valid", 32'(out_valid), 0);
    chk("R1 data", 32'(out_data), 0);
    chk("R1 k", 32'(out_k), 0);
    chk("R1 status", 32'(out_status), 0);
    rst = 1'b0;
    in_valid = 1'b0; in_err = 2'b00; in_k = 2'b00; in_data = 16'h0000;
    drive("R3", 1, 16'h1234, 2'b00, 2'b00);
    drive("R3", 1, 16'hBC1C, 2'b11, 2'b00);
    drive("R7", 1, 16'h00FF, 2'b01, 2'b00);
    drive("R4", 1, 16'h5A33, 2'b00, 2'b01);
    drive("R5", 1, 16'h7C99, 2'b10, 2'b01);
    drive("R5", 1, 16'h6611, 2'b01, 2'b10);
    drive("R4", 1, 16'h0042, 2'b00, 2'b10);
    drive("R6", 1, 16'h1357, 2'b00, 2'b11);
    drive("R6", 1, 16'hFFFF, 2'b11, 2'b11);
    drive("R3", 1, 16'hCAFE, 2'b00, 2'b00);
    drive("R8", 0, 16'hDEAD, 2'b01, 2'b11);
    drive("R8", 0, 16'h4321, 2'b10, 2'b01);
    drive("R2", 1, 16'h8001, 2'b00, 2'b00);
    drive("R8", 0, 16'h0000, 2'b00, 2'b00);
    for (int n = 0; n < 16; n++)
      drive("R5", 1, 16'((n * 16'h1111) ^ 16'h0F0F), 2'(n), 2'(n >> 2));
    drive("R2", 0, 16'h0000, 2'b00, 2'b00);
    repeat (3) @(negedge clk);
    if (q.size() != 0) chk("R2 drain", 32'(q.size()), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog R2 act=%0d exp=0", q.size());
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule